// File: doc/BRIEF.md
# Accumulator Bit-Field Extractor

This unit takes one 64-bit accumulator value and produces a 32-bit result in one of two ways. In shift mode the accumulator is shifted right arithmetically by a 5-bit amount. The shift can round to nearest first and can saturate the result to the signed 32-bit range. Shift mode reports whether the shifted value fits in 32 signed bits.

In field mode a bit field of 1 to 32 bits is read from the accumulator. The field's top bit comes from a 6-bit position pointer supplied by the surrounding control register, and its width comes from the same 5-bit amount operand. If the field would run below bit 0, the extraction is reported as failed. A variant moves the pointer down past the field just read, and wraps it to the top of the accumulator when the field reached bit 0.

Every request is a one-cycle strobe. The result and the control-field updates come out of registers on the following cycle. Each update carries a write strobe, so the owner of the control register knows which fields to overwrite.

Top module: `acc_field_extractor`

## Requirements
- R1: During and directly after synchronous reset, `done`, `ovf_upd`, `fail_upd` and `pos_upd` are 0 and `result` is 0.
- R2: A request with `req_valid`=1 in cycle N gives `done`=1 and all its outputs in cycle N+1. A cycle with `req_valid`=0 gives `done`, `ovf_upd`, `fail_upd` and `pos_upd` equal to 0 in the following cycle.
- R3: Shift mode (`req_field`=0) without rounding returns the low 32 bits of the accumulator shifted right arithmetically by `amt` (0..31). It sets `ovf_upd`=1, `fail_upd`=0 and `pos_upd`=0.
- R4: With `round_en`=1 and `amt`>0, 2^(amt-1) is added to the accumulator before the shift. With `amt`=0 no rounding takes place.
- R5: If the accumulator is positive and the rounding addition overflows past the signed 64-bit maximum, the pre-shift value becomes 2^63-1.
- R6: In shift mode `ovf_flag` is 1 exactly when the shifted 64-bit value lies outside [-2^31, 2^31-1].
- R7: With `sat_en`=1 an out-of-range shifted value gives 0x7FFFFFFF if positive and 0x80000000 if negative. With `sat_en`=0 the result is the low 32 bits.
- R8: Field mode (`req_field`=1) with `cur_pos` >= `amt` returns accumulator bits [cur_pos : cur_pos-amt], right-aligned and zero-extended. It sets `fail_upd`=1, `fail_flag`=0 and `ovf_upd`=0.
- R9: Field mode with `cur_pos` < `amt` gives `fail_flag`=1, `fail_upd`=1, `result`=0 and `pos_upd`=0.
- R10: Field mode with `req_dec`=1 and a successful extraction gives `pos_upd`=1 and `new_pos`=cur_pos-amt-1. With `req_dec`=0 it gives `pos_upd`=0.
- R11: A decrementing extraction with `cur_pos`=`amt` gives `new_pos`=63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_field | input | 1 | 0 = shift mode, 1 = field mode |
| req_dec | input | 1 | Field mode: move the pointer after success |
| round_en | input | 1 | Shift mode: round before shifting |
| sat_en | input | 1 | Shift mode: saturate to signed 32 bits |
| acc_in | input | 64 | Selected accumulator value |
| amt | input | 5 | Shift amount, or field size minus one |
| cur_pos | input | 6 | Current position pointer |
| done | output | 1 | Response valid |
| result | output | 32 | Extracted value |
| ovf_upd | output | 1 | Write strobe for the overflow flag |
| ovf_flag | output | 1 | Overflow flag value |
| fail_upd | output | 1 | Write strobe for the extract-fail flag |
| fail_flag | output | 1 | Extract-fail flag value |
| pos_upd | output | 1 | Write strobe for the position pointer |
| new_pos | output | 6 | New position pointer value |

## Verification
The shift path is tried with exact multiples, negative accumulators, odd values that show whether rounding happened, and the largest positive accumulator with full rounding. That last case separates the positive clamp from a wrapped sum. Values on each side of the 32-bit signed limits separate the overflow flag from saturation. The field path is tried with the pointer above, equal to and below the size, with and without the pointer decrement, and with the widest field at the top bit. A long run of random requests, mixed with idle cycles, is then compared every clock against a behavioural integer model.

// File: rtl/acx_pkg.sv
package acx_pkg;
    localparam int ACC_W = 64;
    localparam int RES_W = 32;
    localparam int SA_W  = $clog2(RES_W);
    localparam int POS_W = $clog2(ACC_W);

    typedef enum logic [1:0] {
        XOP_SHIFT     = 2'd0,
        XOP_FIELD     = 2'd1,
        XOP_FIELD_DEC = 2'd2
    } xop_e;

    typedef struct packed {
        logic             done;
        logic [RES_W-1:0] value;
        logic             ovf_upd;
        logic             ovf;
        logic             fail_upd;
        logic             fail;
        logic             pos_upd;
        logic [POS_W-1:0] pos;
    } xresp_t;

    function automatic xop_e decode_op(input logic field, input logic dec);
        if (!field)   return XOP_SHIFT;
        else if (dec) return XOP_FIELD_DEC;
        else          return XOP_FIELD;
    endfunction
endpackage

// File: rtl/acx_shift_unit.sv
module acx_shift_unit #(
    parameter int ACC_W = 64,
    parameter int RES_W = 32,
    parameter int SA_W  = $clog2(RES_W)
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [SA_W-1:0]  sa,
    input  logic             round_en,
    input  logic             sat_en,
    output logic [RES_W-1:0] value,
    output logic             ovf
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

    logic [ACC_W-1:0]       half;
    logic [ACC_W-1:0]       sum;
    logic [ACC_W-1:0]       pre;
    logic signed [ACC_W-1:0] shifted;
    logic [ACC_W-RES_W:0]   upper;

    always_comb begin
        half = '0;
        if (round_en && sa != '0)
            half = ACC_W'(1) << (sa - 1'b1);
        sum = acc + half;
        // positive input overflowing on the rounding add is pinned high
        if (!acc[ACC_W-1] && acc != '0 && sum[ACC_W-1])
            pre = ACC_MAX;
        else
            pre = sum;
        shifted = $signed(pre) >>> sa;
        upper   = shifted[ACC_W-1:RES_W-1];
        ovf     = !((&upper) || (~|upper));
        if (ovf && sat_en)
            value = shifted[ACC_W-1] ? RES_MIN : RES_MAX;
        else
            value = shifted[RES_W-1:0];
    end
endmodule

// File: rtl/acx_field_unit.sv
module acx_field_unit #(
    parameter int ACC_W = 64,
    parameter int RES_W = 32,
    parameter int SA_W  = $clog2(RES_W),
    parameter int POS_W = $clog2(ACC_W)
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [POS_W-1:0] pos,
    input  logic [SA_W-1:0]  size,
    input  logic             dec,
    output logic [RES_W-1:0] value,
    output logic             ok,
    output logic             pos_upd,
    output logic [POS_W-1:0] new_pos
);
    logic [POS_W-1:0] size_w;
    logic [POS_W-1:0] lo;
    logic [RES_W:0]   mask;
    logic [ACC_W-1:0] window;

    always_comb begin
        size_w  = POS_W'(size);
        ok      = (pos >= size_w);
        lo      = pos - size_w;
        mask    = ((RES_W+1)'(1) << (size_w + 1'b1)) - 1'b1;
        window  = acc >> lo;
        value   = ok ? (window[RES_W-1:0] & mask[RES_W-1:0]) : '0;
        pos_upd = dec && ok;
        // field ending at bit 0 wraps the pointer to the top bit
        if (pos == size_w)
            new_pos = '1;
        else
            new_pos = pos - size_w - 1'b1;
    end
endmodule

// File: rtl/acc_field_extractor.sv
module acc_field_extractor
    import acx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_field,
    input  logic             req_dec,
    input  logic             round_en,
    input  logic             sat_en,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [SA_W-1:0]  amt,
    input  logic [POS_W-1:0] cur_pos,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             ovf_upd,
    output logic             ovf_flag,
    output logic             fail_upd,
    output logic             fail_flag,
    output logic             pos_upd,
    output logic [POS_W-1:0] new_pos
);
    xop_e             op;
    logic [RES_W-1:0] sh_value;
    logic             sh_ovf;
    logic [RES_W-1:0] fd_value;
    logic             fd_ok;
    logic             fd_pos_upd;
    logic [POS_W-1:0] fd_new_pos;
    xresp_t           nxt;
    xresp_t           resp_q;

    assign op = decode_op(req_field, req_dec);

    acx_shift_unit #(.ACC_W(ACC_W), .RES_W(RES_W), .SA_W(SA_W)) u_shift (
        .acc(acc_in), .sa(amt), .round_en(round_en), .sat_en(sat_en),
        .value(sh_value), .ovf(sh_ovf)
    );

    acx_field_unit #(.ACC_W(ACC_W), .RES_W(RES_W), .SA_W(SA_W), .POS_W(POS_W)) u_field (
        .acc(acc_in), .pos(cur_pos), .size(amt), .dec(op == XOP_FIELD_DEC),
        .value(fd_value), .ok(fd_ok), .pos_upd(fd_pos_upd), .new_pos(fd_new_pos)
    );

    always_comb begin
        nxt      = '0;
        nxt.done = req_valid;
        if (req_valid) begin
            unique case (op)
                XOP_SHIFT: begin
                    nxt.value   = sh_value;
                    nxt.ovf_upd = 1'b1;
                    nxt.ovf     = sh_ovf;
                end
                default: begin
                    nxt.value    = fd_value;
                    nxt.fail_upd = 1'b1;
                    nxt.fail     = !fd_ok;
                    nxt.pos_upd  = fd_pos_upd;
                    nxt.pos      = fd_pos_upd ? fd_new_pos : cur_pos;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= nxt;
    end

    assign done      = resp_q.done;
    assign result    = resp_q.value;
    assign ovf_upd   = resp_q.ovf_upd;
    assign ovf_flag  = resp_q.ovf;
    assign fail_upd  = resp_q.fail_upd;
    assign fail_flag = resp_q.fail;
    assign pos_upd   = resp_q.pos_upd;
    assign new_pos   = resp_q.pos;

    assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!done && !ovf_upd && !fail_upd && !pos_upd));
    assert_mode_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (ovf_upd != fail_upd));
    assert_fail_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (fail_upd && fail_flag) |-> (result == '0 && !pos_upd));
    assert_field_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_field && cur_pos >= POS_W'(amt) && amt != '1)
        |=> (result >> ($past(amt) + 1'b1)) == '0);
    assert_pos_only_dec_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_field && req_dec)) |=> !pos_upd);
    assert_wrap_top_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_field && req_dec && cur_pos == POS_W'(amt))
        |=> (pos_upd && new_pos == '1));
endmodule

// File: tb/acc_field_extractor_tb_top.sv
module acc_field_extractor_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_field = 1'b0, req_dec = 1'b0;
    logic        round_en = 1'b0, sat_en = 1'b0;
    logic [63:0] acc_in = '0;
    logic [4:0]  amt = '0;
    logic [5:0]  cur_pos = '0;
    logic        done, ovf_upd, ovf_flag, fail_upd, fail_flag, pos_upd;
    logic [31:0] result;
    logic [5:0]  new_pos;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    acc_field_extractor dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_field(req_field),
        .req_dec(req_dec), .round_en(round_en), .sat_en(sat_en), .acc_in(acc_in),
        .amt(amt), .cur_pos(cur_pos), .done(done), .result(result),
        .ovf_upd(ovf_upd), .ovf_flag(ovf_flag), .fail_upd(fail_upd),
        .fail_flag(fail_flag), .pos_upd(pos_upd), .new_pos(new_pos)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model and check of one request, outputs one cycle later
    task automatic run(input logic [63:0] acc, input int a, input int p,
                       input bit fld, input bit dc, input bit rnd, input bit sat);
        longint s;
        logic [63:0] w;
        logic [31:0] e_res;
        bit e_ov, e_fail, e_pu;
        int e_np;
        string tag;
        req_valid = 1; req_field = fld; req_dec = dc; round_en = rnd; sat_en = sat;
        acc_in = acc; amt = a[4:0]; cur_pos = p[5:0];
        e_ov = 0; e_fail = 0; e_pu = 0; e_np = p;
        if (!fld) begin
            tag = "R3";
            s = acc;
            if (rnd && a > 0) begin
                tag = "R4";
                s = longint'(acc) + (longint'(1) << (a - 1));
                if (longint'(acc) > 0 && s < 0) begin
                    s = 64'sh7FFF_FFFF_FFFF_FFFF;
                    tag = "R5";
                end
            end
            s = s >>> a;
            e_ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            if (e_ov && sat) begin
                e_res = (s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
                tag = "R7";
            end else e_res = s[31:0];
        end else begin
            tag = "R8";
            if (p >= a) begin
                w = acc >> (p - a);
                e_res = w[31:0] & 32'((64'd1 << (a + 1)) - 64'd1);
                if (dc) begin
                    e_pu = 1;
                    e_np = (p == a) ? 63 : p - a - 1;
                end
            end else begin
                e_fail = 1; e_res = '0; tag = "R9";
            end
        end
        @(negedge clk);
        chk("R2", "done", 64'(done), 64'd1);
        chk(tag, "result", 64'(result), 64'(e_res));
        chk(fld ? "R8" : "R6", "ovf_upd", 64'(ovf_upd), 64'(!fld));
        if (!fld) chk("R6", "ovf_flag", 64'(ovf_flag), 64'(e_ov));
        chk(fld ? "R9" : "R3", "fail_upd", 64'(fail_upd), 64'(fld));
        if (fld) chk(e_fail ? "R9" : "R8", "fail_flag", 64'(fail_flag), 64'(e_fail));
        chk("R10", "pos_upd", 64'(pos_upd), 64'(e_pu));
        if (e_pu) chk((p == a) ? "R11" : "R10", "new_pos", 64'(new_pos), 64'(e_np));
    endtask

    task automatic idle();
        req_valid = 0;
        @(negedge clk);
        chk("R2", "idle strobes", {60'd0, done, ovf_upd, fail_upd, pos_upd}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset strobes", {60'd0, done, ovf_upd, fail_upd, pos_upd}, 64'd0);
        chk("R1", "reset result", 64'(result), 64'd0);
        rst = 0;
        @(negedge clk);
        chk("R1", "after reset done", 64'(done), 64'd0);
        // shift mode directed
        run(64'h0000_0001_2345_6780, 4, 0, 0, 0, 0, 0);
        run(-64'sd1000, 3, 0, 0, 0, 0, 0);
        run(64'd5, 1, 0, 0, 0, 0, 0);
        run(64'd5, 1, 0, 0, 0, 1, 0);
        run(64'd7, 0, 0, 0, 0, 1, 0);
        run(64'h7FFF_FFFF_FFFF_FFFF, 31, 0, 0, 0, 1, 0);
        run(64'h7FFF_FFFF_FFFF_FFFF, 31, 0, 0, 0, 1, 1);
        run(64'h0000_0000_8000_0000, 0, 0, 0, 0, 0, 1);
        run(64'h0000_0000_8000_0000, 0, 0, 0, 0, 0, 0);
        run(64'hFFFF_FFFF_7FFF_FFFF, 0, 0, 0, 0, 0, 1);
        run(64'h0000_0000_7FFF_FFFF, 0, 0, 0, 0, 0, 1);
        idle();
        // field mode directed
        run(64'hFEDC_BA98_7654_3210, 7, 15, 1, 0, 0, 0);
        run(64'hFEDC_BA98_7654_3210, 31, 63, 1, 0, 0, 0);
        run(64'hFEDC_BA98_7654_3210, 5, 3, 1, 1, 0, 0);
        run(64'hFEDC_BA98_7654_3210, 4, 20, 1, 1, 0, 0);
        run(64'hFEDC_BA98_7654_3210, 4, 4, 1, 1, 0, 0);
        run(64'hFEDC_BA98_7654_3210, 0, 0, 1, 1, 0, 0);
        idle();
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [63:0] r;
            r = {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) r = {{33{r[63]}}, r[30:0]};
            run(r, int'($urandom_range(0, 31)), int'($urandom_range(0, 63)),
                1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
            if ($urandom_range(0, 4) == 0) idle();
        end
        idle();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule